// File: doc/BRIEF.md
# Input Sample Error Detector

This block watches the I/Q sample pairs that arrive from the data interface and tells the host whether they were captured correctly. The host stores two reference pairs, one for even samples and one for odd samples. Each incoming pair carries a phase tag that picks which reference it is compared against. Every bit that differs from its reference is latched into a per-lane error register, one for I and one for Q. These registers show which bit positions of the interface are failing.

Two compare modes exist. In continuous mode every valid pair is compared. Any mismatch raises the continuous-fail event. A run of matching pairs with both error registers clean raises the pass event. In single-shot mode the host arms one compare. The next valid pair is checked, the arm bit then clears, and a mismatch raises the single-shot-fail event. Each event has its own enable. The interrupt line is active low, and it stays asserted while any enabled event flag is set. The host reads the flag register to learn which event occurred. It then writes ones to clear flags and error bits.

Top module: `sample_err_detect`

## Requirements
- R1: After reset every register reads 0 and `irq_n` is 1.
- R2: A pair with `smp_odd`=0 is compared with the even references (I at address 0, Q at address 1). A pair with `smp_odd`=1 is compared with the odd references (I at address 2, Q at address 3). All four references read back as written.
- R3: Each mismatching bit of a compared pair sets the same bit position of the I error register (address 5) or the Q error register (address 6). These bits stay set until the host clears them.
- R4: Writing to an error register clears exactly the bits written as 1. If a new mismatch happens in the same cycle, setting that bit takes priority over clearing it.
- R5: With continuous compare enabled (control register at address 4, bit 0), a valid pair with any mismatching bit sets flag bit 1 (continuous fail) of the flag register at address 7.
- R6: Flag bit 0 (pass) is set when, in continuous mode, the latest valid pair completes a run of PASS_RUN (16) consecutive matching pairs and both error registers are zero. A mismatch or disabling continuous mode restarts the run. The run saturates, so clearing the error registers after a long matching run lets the next match set the flag.
- R7: Writing 1 to control bit 1 arms a single-shot compare, and bit 1 reads back 1 while armed. The next valid pair is compared and the arm clears. If that pair mismatches, flag bit 2 (single-shot fail) is set; if it matches, no flag is set.
- R8: A cycle with `smp_valid`=0 changes no error bit, flag or arm bit. A valid pair arriving while continuous mode is off and no compare is armed also changes nothing.
- R9: `irq_n` is 0 exactly while some flag bit is set and its enable bit is set. The enable register is at address 8, with bits 0, 1 and 2 matching the flag bits. Writing 1 to a flag bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Captured pair present this cycle |
| smp_odd | input | 1 | Phase tag: 1 selects the odd references |
| smp_i | input | DATA_W | Captured I sample |
| smp_q | input | DATA_W | Captured Q sample |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Write address |
| cfg_wdata | input | DATA_W | Write data |
| cfg_raddr | input | 4 | Read address |
| cfg_rdata | output | DATA_W | Read data (combinational from cfg_raddr) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `smp_valid`, `smp_odd` and the configuration inputs are steady and known around each rising edge. They also assume that a single-shot arm write and a sample are not presented in the same cycle. The bench drives every input a time step after the edge, so nothing changes at the edge itself. It never overlaps an arming write with a valid pair. Register writes and sample cycles are kept in separate clock cycles, except where the bench deliberately tests that a set takes priority over a clear.

// File: rtl/sed_pkg.sv
package sed_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_PAT_I_EVEN = 4'd0;
  localparam logic [ADDR_W-1:0] A_PAT_Q_EVEN = 4'd1;
  localparam logic [ADDR_W-1:0] A_PAT_I_ODD  = 4'd2;
  localparam logic [ADDR_W-1:0] A_PAT_Q_ODD  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CTRL       = 4'd4;
  localparam logic [ADDR_W-1:0] A_ERR_I      = 4'd5;
  localparam logic [ADDR_W-1:0] A_ERR_Q      = 4'd6;
  localparam logic [ADDR_W-1:0] A_FLAGS      = 4'd7;
  localparam logic [ADDR_W-1:0] A_IRQ_EN     = 4'd8;

  localparam int NUM_EVT  = 3;
  localparam int EV_PASS  = 0;
  localparam int EV_AFAIL = 1;
  localparam int EV_SFAIL = 2;

  localparam int NUM_LANE = 2;
  localparam int LANE_I   = 0;
  localparam int LANE_Q   = 1;
endpackage

// File: rtl/sed_pattern_cmp.sv
module sed_pattern_cmp
  import sed_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                           odd,
  input  logic [NUM_LANE-1:0][DATA_W-1:0] smp,
  input  logic [NUM_LANE-1:0][DATA_W-1:0] pat_even,
  input  logic [NUM_LANE-1:0][DATA_W-1:0] pat_odd,
  output logic [NUM_LANE-1:0][DATA_W-1:0] diff
);
  for (genvar ln = 0; ln < NUM_LANE; ln++) begin : g_lane
    logic [DATA_W-1:0] ref_w;
    assign ref_w    = odd ? pat_odd[ln] : pat_even[ln];
    assign diff[ln] = smp[ln] ^ ref_w;
  end
endmodule

// File: rtl/sed_pass_track.sv
module sed_pass_track #(
  parameter int PASS_RUN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic match,
  input  logic clean,
  output logic pass_hit
);
  localparam int RUN_W = $clog2(PASS_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PASS_RUN);

  logic [RUN_W-1:0] run_q, run_d;
  logic             run_en;

  always_comb begin
    run_en = restart || active;
    run_d  = run_q;
    if (restart)           run_d = '0;
    else if (!match)       run_d = '0;
    else if (run_q != RUN_MAX) run_d = run_q + 1'b1;
  end

  assign pass_hit = active && !restart && match && clean && (run_d == RUN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  // R6: the run count never passes its saturation value
  a_r6_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX);
endmodule

// File: rtl/sed_irq.sv
module sed_irq
  import sed_pkg::*;
(
  input  logic [NUM_EVT-1:0] flags,
  input  logic [NUM_EVT-1:0] enables,
  output logic               irq_n
);
  assign irq_n = ~|(flags & enables);
endmodule

// File: rtl/sample_err_detect.sv
module sample_err_detect
  import sed_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PASS_RUN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_odd,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [DATA_W-1:0] smp_q,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] cfg_raddr,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              irq_n
);
  logic [NUM_LANE-1:0][DATA_W-1:0] pat_even_q, pat_odd_q, smp_w, diff_w;
  logic [DATA_W-1:0]  err_i_q, err_i_d, err_q_q, err_q_d;
  logic [NUM_EVT-1:0] flags_q, flags_d, ien_q, evt_set;
  logic               cont_q, cont_d, arm_q, arm_d;
  logic               cmp_hit, mism, pass_hit, clean;
  logic               wr_ctrl, wr_erri, wr_errq, wr_flags, wr_ien;
  logic [3:0]         wr_pat;

  assign smp_w = {smp_q, smp_i};

  sed_pattern_cmp #(.DATA_W(DATA_W)) u_cmp (
    .odd(smp_odd), .smp(smp_w), .pat_even(pat_even_q), .pat_odd(pat_odd_q), .diff(diff_w)
  );

  assign mism    = (|diff_w[LANE_I]) || (|diff_w[LANE_Q]);
  assign cmp_hit = smp_valid && (cont_q || arm_q);
  assign clean   = (err_i_q == '0) && (err_q_q == '0);

  sed_pass_track #(.PASS_RUN(PASS_RUN)) u_pass (
    .clk(clk), .rst_n(rst_n), .restart(!cont_q), .active(cont_q && smp_valid),
    .match(!mism), .clean(clean), .pass_hit(pass_hit)
  );

  // write decode
  always_comb begin
    wr_pat[0] = cfg_wr && (cfg_addr == A_PAT_I_EVEN);
    wr_pat[1] = cfg_wr && (cfg_addr == A_PAT_Q_EVEN);
    wr_pat[2] = cfg_wr && (cfg_addr == A_PAT_I_ODD);
    wr_pat[3] = cfg_wr && (cfg_addr == A_PAT_Q_ODD);
    wr_ctrl   = cfg_wr && (cfg_addr == A_CTRL);
    wr_erri   = cfg_wr && (cfg_addr == A_ERR_I);
    wr_errq   = cfg_wr && (cfg_addr == A_ERR_Q);
    wr_flags  = cfg_wr && (cfg_addr == A_FLAGS);
    wr_ien    = cfg_wr && (cfg_addr == A_IRQ_EN);
  end

  // next state
  always_comb begin
    evt_set           = '0;
    evt_set[EV_PASS]  = pass_hit;
    evt_set[EV_AFAIL] = cont_q && smp_valid && mism;
    evt_set[EV_SFAIL] = arm_q && smp_valid && mism;

    err_i_d = (err_i_q & ~(wr_erri ? cfg_wdata : '0)) | (cmp_hit ? diff_w[LANE_I] : '0);
    err_q_d = (err_q_q & ~(wr_errq ? cfg_wdata : '0)) | (cmp_hit ? diff_w[LANE_Q] : '0);
    flags_d = (flags_q & ~(wr_flags ? cfg_wdata[NUM_EVT-1:0] : '0)) | evt_set;

    cont_d = wr_ctrl ? cfg_wdata[0] : cont_q;
    if (wr_ctrl)                 arm_d = cfg_wdata[1];
    else if (arm_q && smp_valid) arm_d = 1'b0;
    else                         arm_d = arm_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_even_q <= '0;
      pat_odd_q  <= '0;
    end else begin
      if (wr_pat[0]) pat_even_q[LANE_I] <= cfg_wdata;
      if (wr_pat[1]) pat_even_q[LANE_Q] <= cfg_wdata;
      if (wr_pat[2]) pat_odd_q[LANE_I]  <= cfg_wdata;
      if (wr_pat[3]) pat_odd_q[LANE_Q]  <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_i_q <= '0;
      err_q_q <= '0;
      flags_q <= '0;
      ien_q   <= '0;
      cont_q  <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      err_i_q <= err_i_d;
      err_q_q <= err_q_d;
      flags_q <= flags_d;
      cont_q  <= cont_d;
      arm_q   <= arm_d;
      if (wr_ien) ien_q <= cfg_wdata[NUM_EVT-1:0];
    end
  end

  sed_irq u_irq (.flags(flags_q), .enables(ien_q), .irq_n(irq_n));

  // read mux
  always_comb begin
    cfg_rdata = '0;
    case (cfg_raddr)
      A_PAT_I_EVEN: cfg_rdata = pat_even_q[LANE_I];
      A_PAT_Q_EVEN: cfg_rdata = pat_even_q[LANE_Q];
      A_PAT_I_ODD:  cfg_rdata = pat_odd_q[LANE_I];
      A_PAT_Q_ODD:  cfg_rdata = pat_odd_q[LANE_Q];
      A_CTRL:       cfg_rdata = DATA_W'({arm_q, cont_q});
      A_ERR_I:      cfg_rdata = err_i_q;
      A_ERR_Q:      cfg_rdata = err_q_q;
      A_FLAGS:      cfg_rdata = DATA_W'(flags_q);
      A_IRQ_EN:     cfg_rdata = DATA_W'(ien_q);
      default:      cfg_rdata = '0;
    endcase
  end

  // R3: without a write to it, no error bit can drop
  a_r3_err_i_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_erri |=> ((err_i_q & $past(err_i_q)) == $past(err_i_q)));
  a_r3_err_q_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_errq |=> ((err_q_q & $past(err_q_q)) == $past(err_q_q)));
  // R8: idle cycles leave errors, flags and arm untouched
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !cfg_wr) |=> ($stable(err_i_q) && $stable(err_q_q) && $stable(flags_q) && $stable(arm_q)));
  // R7: an armed compare is consumed by one valid pair
  a_r7_arm_once: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && smp_valid && !cfg_wr) |=> !arm_q);
  // R6: pass only rises while both error registers are clean
  a_r6_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[EV_PASS]) |-> (err_i_q == '0 && err_q_q == '0));
  // R9: an enabled, set flag holds the interrupt low
  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_q & ien_q)) |-> !irq_n);
endmodule

// File: tb/sample_err_detect_tb.sv
module sample_err_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0, smp_odd = 1'b0;
  logic [W-1:0]  smp_i = '0, smp_q = '0;
  logic          cfg_wr = 1'b0;
  logic [3:0]    cfg_addr = '0, cfg_raddr = '0;
  logic [W-1:0]  cfg_wdata = '0;
  logic [W-1:0]  cfg_rdata;
  logic          irq_n;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_err_detect u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_odd(smp_odd),
    .smp_i(smp_i), .smp_q(smp_q), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .irq_n(irq_n)
  );

  localparam logic [W-1:0] PIE = 16'hA5A5, PQE = 16'h5A5A, PIO = 16'h3C3C, PQO = 16'hC3C3;

  // {valid, odd, I, Q, expected err I, expected err Q}
  localparam logic [65:0] VEC [8] = '{
    {1'b1, 1'b0, 16'hA5A5, 16'h5A5A, 16'h0000, 16'h0000},
    {1'b1, 1'b1, 16'h3C3C, 16'hC3C3, 16'h0000, 16'h0000},
    {1'b1, 1'b0, 16'hA5A4, 16'h5A5A, 16'h0001, 16'h0000},
    {1'b0, 1'b0, 16'h0000, 16'hFFFF, 16'h0001, 16'h0000},
    {1'b1, 1'b1, 16'h3C3C, 16'hC3C1, 16'h0001, 16'h0002},
    {1'b1, 1'b0, 16'h25A5, 16'h5A5A, 16'h8001, 16'h0002},
    {1'b1, 1'b1, 16'h3C3C, 16'h43C3, 16'h8001, 16'h8002},
    {1'b1, 1'b0, 16'hA5A5, 16'h5A5A, 16'h8001, 16'h8002}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    cfg_raddr = a; #1; d = cfg_rdata;
  endtask

  task automatic smp(input logic v, input logic o, input logic [W-1:0] i, input logic [W-1:0] q);
    smp_valid = v; smp_odd = o; smp_i = i; smp_q = q;
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic good(input int n);
    for (int k = 0; k < n; k++) begin
      if (k % 2 == 0) smp(1'b1, 1'b0, PIE, PQE);
      else            smp(1'b1, 1'b1, PIO, PQO);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), r); check("R1 reg", r, '0);
    end
    check("R1 irq_n", {15'd0, irq_n}, 16'd1);

    // R2: reference readback
    wr(4'd0, PIE); wr(4'd1, PQE); wr(4'd2, PIO); wr(4'd3, PQO);
    rd(4'd0, r); check("R2 pat I even", r, PIE);
    rd(4'd1, r); check("R2 pat Q even", r, PQE);
    rd(4'd2, r); check("R2 pat I odd", r, PIO);
    rd(4'd3, r); check("R2 pat Q odd", r, PQO);

    // R8: compare disabled, mismatching valid pair ignored
    smp(1'b1, 1'b0, 16'hFFFF, 16'hFFFF);
    rd(4'd5, r); check("R8 off err I", r, '0);
    rd(4'd7, r); check("R8 off flags", r, '0);

    // table walk: R2/R3/R8 with continuous compare on
    wr(4'd4, 16'd1);
    for (int s = 0; s < 8; s++) begin
      smp(VEC[s][65], VEC[s][64], VEC[s][63:48], VEC[s][47:32]);
      rd(4'd5, r); check($sformatf("R3 vec%0d err I", s), r, VEC[s][31:16]);
      rd(4'd6, r); check($sformatf("R3 vec%0d err Q", s), r, VEC[s][15:0]);
    end
    // R5 continuous fail flag, R9 no enable -> no irq
    rd(4'd7, r); check("R5 fail flag", r, 16'h0002);
    check("R9 irq masked", {15'd0, irq_n}, 16'd1);
    wr(4'd8, 16'h0002);
    check("R9 irq asserted", {15'd0, irq_n}, 16'd0);
    wr(4'd7, 16'h0002);
    rd(4'd7, r); check("R9 flag cleared", r, '0);
    check("R9 irq released", {15'd0, irq_n}, 16'd1);

    // R4: partial clear
    wr(4'd5, 16'h0001);
    rd(4'd5, r); check("R4 partial clear", r, 16'h8000);
    // R4: set beats clear in the same cycle
    cfg_wr = 1'b1; cfg_addr = 4'd6; cfg_wdata = 16'hFFFF;
    smp(1'b1, 1'b0, PIE, PQE ^ 16'h0010);
    cfg_wr = 1'b0;
    rd(4'd6, r); check("R4 set wins", r, 16'h0010);
    wr(4'd5, 16'hFFFF); wr(4'd6, 16'hFFFF); wr(4'd7, 16'h0007);

    // R6: run of PASS_RUN matches
    wr(4'd4, 16'd0); wr(4'd4, 16'd1);
    wr(4'd8, 16'h0001);
    good(15);
    rd(4'd7, r); check("R6 15 matches", r, 16'h0000);
    good(1);
    rd(4'd7, r); check("R6 16 matches", r, 16'h0001);
    check("R9 irq on pass", {15'd0, irq_n}, 16'd0);
    wr(4'd7, 16'h0007);
    // R6: mismatch restarts the run
    smp(1'b1, 1'b1, PIO ^ 16'h0100, PQO);
    wr(4'd5, 16'hFFFF); wr(4'd7, 16'h0007);
    good(15);
    rd(4'd7, r); check("R6 restart 15", r, 16'h0000);
    good(1);
    rd(4'd7, r); check("R6 restart 16", r, 16'h0001);
    wr(4'd7, 16'h0007);
    // R6: dirty error register blocks pass until cleared
    smp(1'b1, 1'b0, PIE, PQE ^ 16'h0004);
    wr(4'd7, 16'h0007);
    good(20);
    rd(4'd7, r); check("R6 blocked by errors", r, 16'h0000);
    wr(4'd6, 16'hFFFF);
    good(1);
    rd(4'd7, r); check("R6 after clear", r, 16'h0001);
    wr(4'd7, 16'h0007);

    // R7: single-shot
    wr(4'd4, 16'd0); wr(4'd8, 16'h0004);
    wr(4'd4, 16'd2);
    rd(4'd4, r); check("R7 armed", r, 16'h0002);
    smp(1'b0, 1'b0, 16'h0000, 16'h0000);
    rd(4'd4, r); check("R8 invalid keeps arm", r, 16'h0002);
    smp(1'b1, 1'b1, PIO ^ 16'h0800, PQO);
    rd(4'd4, r); check("R7 arm consumed", r, 16'h0000);
    rd(4'd7, r); check("R7 shot fail", r, 16'h0004);
    rd(4'd5, r); check("R7 shot err I", r, 16'h0800);
    check("R9 irq on shot", {15'd0, irq_n}, 16'd0);
    smp(1'b1, 1'b1, PIO ^ 16'h0001, PQO);
    rd(4'd5, r); check("R8 unarmed ignored", r, 16'h0800);
    wr(4'd7, 16'h0007);
    wr(4'd4, 16'd2);
    smp(1'b1, 1'b0, PIE, PQE);
    rd(4'd7, r); check("R7 match no flag", r, 16'h0000);
    check("R9 irq idle", {15'd0, irq_n}, 16'd1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule